// File: doc/BRIEF.md
# Timestamping inter-processor FIFO

This block is a synchronous first-in first-out queue that carries events from one application processor to a supervising monitor. Every time the producer pushes an event (a 2-bit event code and a block identifier), the queue stores it together with the value of the producer's free-running 32-bit cycle counter in that same cycle. The monitor later pops entries and gets the code, the block identifier and the captured timestamp. From these it can work out how long each block took.

Neither side ever loses data. A push made while the queue is full is refused and raises a stall output. A pop made while the queue is empty is refused the same way. A stalled requester keeps its request asserted until the queue accepts it. The popped entry appears on registered outputs one cycle after the pop is accepted. When the queue is empty and nothing is being popped, the output code field shows the "not ready" code so that downstream logic sees that no data is waiting. The block does not interpret, decrypt or check the payload.

Event code encoding: 0 means block start, 1 means block end, 2 means not ready and 3 means application finished.

Top module: `stamp_fifo`

## Requirements
- R1: While reset is active and right after it, `empty`=1, `full`=0, `push_stall`=0 when no push is requested, `out_valid`=0 and `out_code`=2.
- R2: Entries come out in the order they were accepted. Each entry carries the code and block identifier that were on `in_code` and `in_blk` in its push cycle.
- R3: The `out_stamp` of each popped entry equals the value of `cycle_cnt` in the cycle in which the push was accepted.
- R4: A push requested while `full`=1 is not accepted, and `push_stall`=1 in that cycle. This holds even when a pop is accepted in the same cycle. A refused push leaves no entry behind.
- R5: A pop requested while `empty`=1 is not accepted, and `pop_stall`=1 in that cycle. In the next cycle `out_valid`=0.
- R6: When a pop is accepted, the next cycle has `out_valid`=1 with the popped entry on the outputs. In any cycle that follows a cycle without an accepted pop, `out_valid`=0.
- R7: `full`=1 exactly when DEPTH entries are held, and `empty`=1 exactly when none are held. A push and a pop accepted in the same cycle leave the fill level unchanged.
- R8: In the cycle after a cycle in which the queue was empty and no pop was accepted, `out_code`=2.
- R9: All four code values, including 2 and 3, are stored and returned unchanged as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Producer push request, held while stalled |
| in_code | input | 2 | Event code to store |
| in_blk | input | BLK_W | Block identifier to store |
| cycle_cnt | input | 32 | Producer free-running cycle count |
| push_stall | output | 1 | Push requested while full; not accepted |
| full | output | 1 | Queue holds DEPTH entries |
| pop_req | input | 1 | Consumer pop request, held while stalled |
| pop_stall | output | 1 | Pop requested while empty; not accepted |
| empty | output | 1 | Queue holds no entries |
| out_valid | output | 1 | Outputs carry an entry popped in the previous cycle |
| out_code | output | 2 | Popped event code, or 2 when empty |
| out_blk | output | BLK_W | Popped block identifier |
| out_stamp | output | 32 | Popped timestamp |

## Verification
The flags and both stall outputs depend only on the fill level and the present requests, so they are due in the same cycle as the request. The output register, including the forced "not ready" code, is due exactly one edge after the cycle that was accepted. The bench's behavioural queue model updates at each rising edge from the inputs held since the previous falling edge. Every output is compared with the model at the following falling edge, one register stage after the stimulus that produced it. The stamp is checked against a counter that changes only on falling edges, so the value sampled at the push edge is unambiguous.

// File: rtl/stamp_fifo_pkg.sv
package stamp_fifo_pkg;
  localparam int unsigned STAMP_W = 32;
  localparam int unsigned CODE_W  = 2;

  typedef enum logic [CODE_W-1:0] {
    EV_START = 2'd0,
    EV_END   = 2'd1,
    EV_IDLE  = 2'd2,
    EV_DONE  = 2'd3
  } ev_code_t;
endpackage

// File: rtl/stamp_fifo_ptr.sv
module stamp_fifo_ptr #(
  parameter int unsigned AW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [AW:0] ptr
);
  function automatic logic [AW:0] ptr_next(input logic [AW:0] p);
    return p + {{AW{1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_next(ptr);
  end
endmodule

// File: rtl/stamp_fifo_store.sv
module stamp_fifo_store #(
  parameter int unsigned AW = 3,
  parameter int unsigned W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned SLOTS = 1 << AW;
  logic [W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/stamp_fifo_out.sv
module stamp_fifo_out
  import stamp_fifo_pkg::*;
#(
  parameter int unsigned BLK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               idle,
  input  logic [CODE_W-1:0]  ld_code,
  input  logic [BLK_W-1:0]   ld_blk,
  input  logic [STAMP_W-1:0] ld_stamp,
  output logic               out_valid,
  output logic [CODE_W-1:0]  out_code,
  output logic [BLK_W-1:0]   out_blk,
  output logic [STAMP_W-1:0] out_stamp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= EV_IDLE;
      out_blk   <= '0;
      out_stamp <= '0;
    end else begin
      out_valid <= load;
      if (load) begin
        out_code  <= ld_code;
        out_blk   <= ld_blk;
        out_stamp <= ld_stamp;
      end else if (idle) begin
        out_code  <= EV_IDLE;
      end
    end
  end
endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo
  import stamp_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BLK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_req,
  input  logic [CODE_W-1:0]  in_code,
  input  logic [BLK_W-1:0]   in_blk,
  input  logic [STAMP_W-1:0] cycle_cnt,
  output logic               push_stall,
  output logic               full,
  input  logic               pop_req,
  output logic               pop_stall,
  output logic               empty,
  output logic               out_valid,
  output logic [CODE_W-1:0]  out_code,
  output logic [BLK_W-1:0]   out_blk,
  output logic [STAMP_W-1:0] out_stamp
);
  localparam int unsigned AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;
  localparam int unsigned EW = CODE_W + BLK_W + STAMP_W;

  function automatic logic [LW-1:0] fill_level(input logic [LW-1:0] w, input logic [LW-1:0] r);
    return w - r;
  endfunction

  logic [LW-1:0] wr_ptr, rd_ptr, level;
  logic          push_ok, pop_ok;
  logic [EW-1:0] wr_word, rd_word;

  assign level      = fill_level(wr_ptr, rd_ptr);
  assign empty      = (level == '0);
  assign full       = (level == LW'(DEPTH));
  assign push_ok    = push_req && !full;
  assign pop_ok     = pop_req && !empty;
  assign push_stall = push_req && full;
  assign pop_stall  = pop_req && empty;
  assign wr_word    = {in_code, in_blk, cycle_cnt};

  stamp_fifo_ptr #(.AW(AW)) u_wptr (.clk(clk), .rst_n(rst_n), .adv(push_ok), .ptr(wr_ptr));
  stamp_fifo_ptr #(.AW(AW)) u_rptr (.clk(clk), .rst_n(rst_n), .adv(pop_ok),  .ptr(rd_ptr));

  stamp_fifo_store #(.AW(AW), .W(EW)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr[AW-1:0]), .wdata(wr_word),
    .raddr(rd_ptr[AW-1:0]), .rdata(rd_word)
  );

  stamp_fifo_out #(.BLK_W(BLK_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(pop_ok), .idle(empty),
    .ld_code(rd_word[EW-1 -: CODE_W]),
    .ld_blk(rd_word[STAMP_W +: BLK_W]),
    .ld_stamp(rd_word[STAMP_W-1:0]),
    .out_valid(out_valid), .out_code(out_code),
    .out_blk(out_blk), .out_stamp(out_stamp)
  );
endmodule

// File: rtl/stamp_fifo_chk.sv
module stamp_fifo_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          pop_req,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          full,
  input logic          empty,
  input logic          out_valid,
  input logic [1:0]    out_code,
  input logic [LW-1:0] level
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R7
  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (level == $past(level) + LW'(1))); // R7
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (level == $past(level))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_ok) |=> full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req) |=> !out_valid); // R5
  AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> out_valid); // R6
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !pop_ok) |=> (out_code == 2'd2)); // R8
endmodule

bind stamp_fifo stamp_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
  .push_ok(push_ok), .pop_ok(pop_ok), .full(full), .empty(empty),
  .out_valid(out_valid), .out_code(out_code), .level(level)
);

// File: tb/stamp_fifo_test.sv
`timescale 1ns/1ps
module stamp_fifo_test;
  localparam int DEPTH = 8;
  localparam int BW    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_req = 1'b0, pop_req = 1'b0;
  logic [1:0] in_code = 2'd0;
  logic [BW-1:0] in_blk = '0;
  logic [31:0] cyc = 32'h1000_0000;
  logic push_stall, full, pop_stall, empty, out_valid;
  logic [1:0] out_code;
  logic [BW-1:0] out_blk;
  logic [31:0] out_stamp;

  int checks = 0, errors = 0, ticks = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 32'd7;

  stamp_fifo #(.DEPTH(DEPTH), .BLK_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .in_code(in_code),
    .in_blk(in_blk), .cycle_cnt(cyc), .push_stall(push_stall), .full(full),
    .pop_req(pop_req), .pop_stall(pop_stall), .empty(empty),
    .out_valid(out_valid), .out_code(out_code), .out_blk(out_blk),
    .out_stamp(out_stamp)
  );

  typedef struct packed { logic [1:0] c; logic [BW-1:0] b; logic [31:0] s; } ent_t;
  ent_t mq[$];
  logic       m_valid = 1'b0;
  logic [1:0] m_code  = 2'd2;
  logic [BW-1:0] m_blk = '0;
  logic [31:0] m_stamp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_valid = 1'b0; m_code = 2'd2; m_blk = '0; m_stamp = '0;
    end else begin
      bit pok, wok;
      pok = pop_req && (mq.size() != 0);
      wok = push_req && (mq.size() != DEPTH);
      if (pok) begin
        ent_t e;
        e = mq.pop_front();
        m_valid = 1'b1; m_code = e.c; m_blk = e.b; m_stamp = e.s;
      end else begin
        m_valid = 1'b0;
        if (mq.size() == 0) m_code = 2'd2;
      end
      if (wok) mq.push_back('{c: in_code, b: in_blk, s: cyc});
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit me, mf;
    me = (mq.size() == 0);
    mf = (mq.size() == DEPTH);
    chk(empty == me, "R7 empty", empty, me);
    chk(full == mf, "R7 full", full, mf);
    chk(push_stall == (push_req && mf), "R4 push_stall", push_stall, push_req && mf);
    chk(pop_stall == (pop_req && me), "R5 pop_stall", pop_stall, pop_req && me);
    chk(out_valid == m_valid, "R6 out_valid", out_valid, m_valid);
    chk(out_code == m_code, "R2 R8 R9 out_code", out_code, m_code);
    if (m_valid) begin
      chk(out_blk == m_blk, "R2 out_blk", out_blk, m_blk);
      chk(out_stamp == m_stamp, "R3 out_stamp", out_stamp, m_stamp);
    end
  endtask

  task automatic step(input bit p, input logic [1:0] c, input logic [BW-1:0] b, input bit r);
    @(negedge clk);
    compare_all();
    push_req = p; in_code = c; in_blk = b; pop_req = r;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(empty == 1'b1 && full == 1'b0, "R1 flags in reset", {full, empty}, 2'b01);
    chk(out_valid == 1'b0 && out_code == 2'd2, "R1 outputs in reset", {out_valid, out_code}, 3'b010);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    chk(push_stall == 1'b0 && out_code == 2'd2, "R1 after reset", {push_stall, out_code}, 3'b010);
    // R5 R8: pops into an empty queue
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
    // R9 R3: all codes, stamps, same cycle push+pop on empty
    step(1, 2'd0, 8'h11, 1);
    step(1, 2'd1, 8'h22, 0);
    step(1, 2'd2, 8'h33, 0);
    step(1, 2'd3, 8'h44, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
    // R7 R4: fill, overfill, push+pop while full
    for (int i = 0; i < DEPTH + 3; i++) step(1, 2'(i), 8'(8'h50 + i), 0);
    step(1, 2'd3, 8'hEE, 1);
    step(1, 2'd1, 8'hA0, 1);
    for (int i = 0; i < 6; i++) step(1, 2'(i), 8'(8'hB0 + i), 1);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1);
    // mixed traffic
    for (int i = 0; i < 40; i++) step((i % 3) != 0, 2'(i >> 1), 8'(i * 5), (i % 4) == 1);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", ticks);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule